// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller decides which of three low-power states a microcontroller enters when its processor issues a sleep request. It also decides which events bring the chip back. The request carries its instruction kind: wait-for-interrupt or wait-for-event. Together with a deep-sleep flag and a low-power-mode bit, that kind selects one of three states. Sleep gates only the core clock. Wait gates the core, peripheral and memory clocks but keeps every domain powered. Backup also turns the core regulator off and leaves only the always-on region running.

Between an accepted request and the state change there is a fixed resynchronisation window. A wake event that the target state would honour cancels the entry if it arrives inside that window. Each state has its own set of wake sources. Leaving Backup raises a one-cycle reset request to the core. Leaving Sleep or Wait simply re-enables the clocks. Wake-up pins have a per-pin enable and polarity. Backup uses a debounced view of the pins, counted in ticks of the slow clock. Sleep and Wait use the raw enabled level as a fast-startup source.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the block reports Active (status code 0), with core clock, peripheral clock and regulator enables all 1, reset request 0 and the rejected-wait flag 0.
- R2: A wait-for-event request with the deep-sleep flag at 1 enters Backup: status 3, and regulator, core clock and peripheral clock enables all 0.
- R3: A wait-for-event request with deep-sleep 0 and low-power bit 1, while the main clock is the RC oscillator, enters Wait: status 2, core and peripheral clocks 0, regulator 1.
- R4: A wait-for-interrupt request, whatever the flags, or a wait-for-event request with both flags at 0, enters Sleep: status 1, core clock 0, peripheral clock and regulator 1.
- R5: For RESYNC cycles after an accepted request the status stays 0 and all enables stay 1. The target state appears at the RESYNC-th clock edge after the edge that sampled the request.
- R6: A Wait request made while the main clock is not the RC oscillator is ignored: the block stays Active and the rejected-wait flag goes to 1. The next accepted request clears the flag.
- R7: Backup wakes on a debounced wake pin, a supply-monitor alarm, an RTC alarm or an RTT alarm. A USB wake or a pending interrupt has no effect. On exit the block spends one cycle with reset request 1, status 0 and regulator 1, then returns to Active.
- R8: In Backup a pin counts as woken only if it is enabled and at its active level (active high when its polarity bit is 1) for debounceLen slow-clock ticks. A length of 0 means it counts at once. A disabled pin never wakes.
- R9: Wait wakes on an enabled pin at its active level (not debounced), an RTC alarm, an RTT alarm or a USB wake. The block is Active the next cycle and reset request stays 0. A supply-monitor alarm or a pending interrupt has no effect.
- R10: Sleep entered by wait-for-interrupt wakes only on a pending interrupt. Sleep entered by wait-for-event also wakes on any of the Wait wake events.
- R11: A wake event valid for the target state that occurs during the entry window returns the block to Active, and the target state is never entered.
- R12: Sleep requests that arrive while the block is not Active have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slowTick | input | 1 | One-cycle pulse per slow-clock period, drives debounce |
| sleepReq | input | 1 | Sleep request strobe from the processor |
| reqIsWfe | input | 1 | 1 = wait-for-event request, 0 = wait-for-interrupt |
| deepSleep | input | 1 | Deep-sleep flag |
| lowPowerMode | input | 1 | Low-power-mode bit |
| mainClkIsRc | input | 1 | 1 when the main clock is the fast RC oscillator |
| wakePin | input | NUM_PINS | Wake-up pin levels |
| wakeEnable | input | NUM_PINS | Per-pin wake enable |
| wakeActiveHigh | input | NUM_PINS | Per-pin polarity, 1 = active high |
| debounceLen | input | DEB_W | Debounce length in slow ticks, 0 = none |
| smAlarm | input | 1 | Supply-monitor alarm |
| rtcAlarm | input | 1 | RTC alarm |
| rttAlarm | input | 1 | RTT alarm |
| usbWake | input | 1 | USB wake event |
| irqPending | input | 1 | Any enabled interrupt pending |
| coreClkEn | output | 1 | Core clock enable |
| perClkEn | output | 1 | Peripheral and memory clock enable |
| regulatorEn | output | 1 | Core regulator enable |
| resetReq | output | 1 | Core reset request on exit from Backup |
| modeStatus | output | 2 | Current state: 0 Active, 1 Sleep, 2 Wait, 3 Backup |
| waitRejected | output | 1 | A Wait request was refused for a non-RC main clock |

## Verification
Requests are driven with every mix of instruction kind, deep-sleep flag and low-power bit, including wait-for-interrupt with both flags set. This separates the decode order from a plain bit lookup. In each state the bench first applies wake sources that belong only to another state (USB in Backup, supply monitor in Wait, USB in wait-for-interrupt Sleep) and then one valid source. This tells the per-state wake sets apart. Pins are tested active low with several slow ticks, with zero debounce and while disabled. Requests are also sent with a non-RC clock and during the entry window, which separates a refused request and a cancelled entry from a normal one.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_SLEEP  = 2'd1,
    MODE_WAIT   = 2'd2,
    MODE_BACKUP = 2'd3
  } lpmMode_t;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_ENTRY,
    ST_SLEEP,
    ST_WAIT,
    ST_BACKUP,
    ST_WAKERST
  } lpmState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrDebounce;
  } ctrlStrobe_t;

  // datapath -> control wake summaries
  typedef struct packed {
    logic backupWake;
    logic fastWake;
  } wakeFlags_t;

endpackage

// File: rtl/lpm_wake_path.sv
module lpm_wake_path
  import lpm_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DEB_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slowTick,
  input  logic [NUM_PINS-1:0] wakePin,
  input  logic [NUM_PINS-1:0] wakeEnable,
  input  logic [NUM_PINS-1:0] wakeActiveHigh,
  input  logic [DEB_W-1:0]    debounceLen,
  input  logic                smAlarm,
  input  logic                rtcAlarm,
  input  logic                rttAlarm,
  input  logic                usbWake,
  input  ctrlStrobe_t         strobe,
  output wakeFlags_t          flags
);

  logic [NUM_PINS-1:0] pinQual;
  logic [NUM_PINS-1:0] pinSettled;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [DEB_W-1:0] debCnt;

    assign pinQual[i] = wakeEnable[i] & ~(wakePin[i] ^ wakeActiveHigh[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        debCnt <= '0;
      end else if (strobe.clrDebounce || !pinQual[i]) begin
        debCnt <= '0;
      end else if (slowTick && (debCnt < debounceLen)) begin
        debCnt <= debCnt + 1'b1;
      end
    end

    assign pinSettled[i] = pinQual[i] & (debCnt >= debounceLen);

    // a pin that drops out of its qualified level restarts its count
    p_deb_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
      !pinQual[i] |=> (debCnt == '0));
  end

  always_comb begin
    flags.fastWake   = (|pinQual) | rtcAlarm | rttAlarm | usbWake;
    flags.backupWake = (|pinSettled) | smAlarm | rtcAlarm | rttAlarm;
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int RESYNC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        reqIsWfe,
  input  logic        deepSleep,
  input  logic        lowPowerMode,
  input  logic        mainClkIsRc,
  input  logic        irqPending,
  input  wakeFlags_t  flags,
  output ctrlStrobe_t strobe,
  output logic        coreClkEn,
  output logic        perClkEn,
  output logic        regulatorEn,
  output logic        resetReq,
  output logic [1:0]  modeStatus,
  output logic        waitRejected
);

  localparam int CW = (RESYNC > 1) ? $clog2(RESYNC) : 1;

  lpmState_t      state;
  lpmMode_t       target;
  logic           byWfe;
  logic [CW-1:0]  windowCnt;
  logic           waitRej;

  lpmMode_t decodeMode;
  logic     rejectNow;
  logic     acceptNow;
  logic     targetWake;

  always_comb begin
    if (reqIsWfe && deepSleep)         decodeMode = MODE_BACKUP;
    else if (reqIsWfe && lowPowerMode) decodeMode = MODE_WAIT;
    else                               decodeMode = MODE_SLEEP;
    rejectNow = (decodeMode == MODE_WAIT) && !mainClkIsRc;
    acceptNow = (state == ST_ACTIVE) && sleepReq && !rejectNow;
    strobe.clrDebounce = acceptNow;
    case (target)
      MODE_SLEEP:  targetWake = irqPending | (byWfe & flags.fastWake);
      MODE_WAIT:   targetWake = flags.fastWake;
      MODE_BACKUP: targetWake = flags.backupWake;
      default:     targetWake = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ACTIVE;
      target    <= MODE_SLEEP;
      byWfe     <= 1'b0;
      windowCnt <= '0;
      waitRej   <= 1'b0;
    end else begin
      case (state)
        ST_ACTIVE: begin
          if (sleepReq) begin
            if (rejectNow) begin
              waitRej <= 1'b1;
            end else begin
              waitRej   <= 1'b0;
              target    <= decodeMode;
              byWfe     <= reqIsWfe;
              windowCnt <= CW'(RESYNC - 1);
              state     <= ST_ENTRY;
            end
          end
        end
        ST_ENTRY: begin
          if (targetWake) begin
            state <= ST_ACTIVE;
          end else if (windowCnt == '0) begin
            case (target)
              MODE_WAIT:   state <= ST_WAIT;
              MODE_BACKUP: state <= ST_BACKUP;
              default:     state <= ST_SLEEP;
            endcase
          end else begin
            windowCnt <= windowCnt - 1'b1;
          end
        end
        ST_SLEEP:   if (targetWake) state <= ST_ACTIVE;
        ST_WAIT:    if (targetWake) state <= ST_ACTIVE;
        ST_BACKUP:  if (targetWake) state <= ST_WAKERST;
        ST_WAKERST: state <= ST_ACTIVE;
        default:    state <= ST_ACTIVE;
      endcase
    end
  end

  always_comb begin
    coreClkEn   = 1'b1;
    perClkEn    = 1'b1;
    regulatorEn = 1'b1;
    resetReq    = 1'b0;
    modeStatus  = MODE_ACTIVE;
    case (state)
      ST_SLEEP: begin
        coreClkEn  = 1'b0;
        modeStatus = MODE_SLEEP;
      end
      ST_WAIT: begin
        coreClkEn  = 1'b0;
        perClkEn   = 1'b0;
        modeStatus = MODE_WAIT;
      end
      ST_BACKUP: begin
        coreClkEn   = 1'b0;
        perClkEn    = 1'b0;
        regulatorEn = 1'b0;
        modeStatus  = MODE_BACKUP;
      end
      ST_WAKERST: begin
        coreClkEn = 1'b0;
        perClkEn  = 1'b0;
        resetReq  = 1'b1;
      end
      default: ;
    endcase
  end

  assign waitRejected = waitRej;

  p_wait_rc_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && sleepReq && reqIsWfe && !deepSleep && lowPowerMode && !mainClkIsRc)
    |=> (state == ST_ACTIVE && waitRejected));

  p_backup_exit_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BACKUP && flags.backupWake) |=> (resetReq && regulatorEn));

  p_wait_exit_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && flags.fastWake) |=> (modeStatus == MODE_ACTIVE && !resetReq));

  p_wfi_irq_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !byWfe && !irqPending) |=> (state == ST_SLEEP));

  p_entry_cancel_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ENTRY && targetWake) |=> (state == ST_ACTIVE));

  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !targetWake) |=> (state == ST_SLEEP && $stable(target)));

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DEB_W    = 4,
  parameter int RESYNC   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slowTick,
  input  logic                sleepReq,
  input  logic                reqIsWfe,
  input  logic                deepSleep,
  input  logic                lowPowerMode,
  input  logic                mainClkIsRc,
  input  logic [NUM_PINS-1:0] wakePin,
  input  logic [NUM_PINS-1:0] wakeEnable,
  input  logic [NUM_PINS-1:0] wakeActiveHigh,
  input  logic [DEB_W-1:0]    debounceLen,
  input  logic                smAlarm,
  input  logic                rtcAlarm,
  input  logic                rttAlarm,
  input  logic                usbWake,
  input  logic                irqPending,
  output logic                coreClkEn,
  output logic                perClkEn,
  output logic                regulatorEn,
  output logic                resetReq,
  output logic [1:0]          modeStatus,
  output logic                waitRejected
);

  ctrlStrobe_t strobe;
  wakeFlags_t  flags;

  lpm_wake_path #(.NUM_PINS(NUM_PINS), .DEB_W(DEB_W)) u_wake (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .wakePin(wakePin), .wakeEnable(wakeEnable), .wakeActiveHigh(wakeActiveHigh),
    .debounceLen(debounceLen), .smAlarm(smAlarm), .rtcAlarm(rtcAlarm),
    .rttAlarm(rttAlarm), .usbWake(usbWake), .strobe(strobe), .flags(flags)
  );

  lpm_ctrl #(.RESYNC(RESYNC)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .reqIsWfe(reqIsWfe),
    .deepSleep(deepSleep), .lowPowerMode(lowPowerMode), .mainClkIsRc(mainClkIsRc),
    .irqPending(irqPending), .flags(flags), .strobe(strobe),
    .coreClkEn(coreClkEn), .perClkEn(perClkEn), .regulatorEn(regulatorEn),
    .resetReq(resetReq), .modeStatus(modeStatus), .waitRejected(waitRejected)
  );

endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;

  localparam int NP = 16;
  localparam int DW = 4;
  localparam int RS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 0, sleepReq = 0, reqIsWfe = 0, deepSleep = 0, lowPowerMode = 0;
  logic mainClkIsRc = 1;
  logic [NP-1:0] wakePin = '0, wakeEnable = '0, wakeActiveHigh = '1;
  logic [DW-1:0] debounceLen = '0;
  logic smAlarm = 0, rtcAlarm = 0, rttAlarm = 0, usbWake = 0, irqPending = 0;
  logic coreClkEn, perClkEn, regulatorEn, resetReq, waitRejected;
  logic [1:0] modeStatus;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpm_sequencer #(.NUM_PINS(NP), .DEB_W(DW), .RESYNC(RS)) dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .sleepReq(sleepReq),
    .reqIsWfe(reqIsWfe), .deepSleep(deepSleep), .lowPowerMode(lowPowerMode),
    .mainClkIsRc(mainClkIsRc), .wakePin(wakePin), .wakeEnable(wakeEnable),
    .wakeActiveHigh(wakeActiveHigh), .debounceLen(debounceLen), .smAlarm(smAlarm),
    .rtcAlarm(rtcAlarm), .rttAlarm(rttAlarm), .usbWake(usbWake), .irqPending(irqPending),
    .coreClkEn(coreClkEn), .perClkEn(perClkEn), .regulatorEn(regulatorEn),
    .resetReq(resetReq), .modeStatus(modeStatus), .waitRejected(waitRejected)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(logic wfe, logic deep, logic lp);
    reqIsWfe = wfe; deepSleep = deep; lowPowerMode = lp; sleepReq = 1'b1;
    cyc(1);
    sleepReq = 1'b0;
  endtask

  task automatic tickPulse();
    slowTick = 1'b1; cyc(1); slowTick = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 status", modeStatus, 0);
    chk("R1 core", coreClkEn, 1);
    chk("R1 per", perClkEn, 1);
    chk("R1 reg", regulatorEn, 1);
    chk("R1 rst", resetReq, 0);
    chk("R1 rej", waitRejected, 0);
  endtask

  task automatic t_sleep_wfi();
    request(1'b0, 1'b1, 1'b1);
    cyc(RS - 1);
    chk("R5 window status", modeStatus, 0);
    chk("R5 window core", coreClkEn, 1);
    cyc(1);
    chk("R4 wfi status", modeStatus, 1);
    chk("R4 core", coreClkEn, 0);
    chk("R4 per", perClkEn, 1);
    chk("R4 reg", regulatorEn, 1);
    usbWake = 1; cyc(2); usbWake = 0;
    chk("R10 wfi ignores usb", modeStatus, 1);
    irqPending = 1; cyc(1); irqPending = 0;
    chk("R10 wfi irq wake", modeStatus, 0);
    chk("R10 core back", coreClkEn, 1);
  endtask

  task automatic t_sleep_wfe();
    request(1'b1, 1'b0, 1'b0);
    cyc(RS);
    chk("R4 wfe status", modeStatus, 1);
    request(1'b1, 1'b1, 1'b0);
    cyc(RS + 1);
    chk("R12 busy request ignored", modeStatus, 1);
    rttAlarm = 1; cyc(1); rttAlarm = 0;
    chk("R10 wfe rtt wake", modeStatus, 0);
    cyc(1);
  endtask

  task automatic t_wait();
    mainClkIsRc = 1;
    wakeEnable = 16'h0020; wakeActiveHigh = 16'hFFFF; debounceLen = 4'd7;
    request(1'b1, 1'b0, 1'b1);
    cyc(RS);
    chk("R3 status", modeStatus, 2);
    chk("R3 core", coreClkEn, 0);
    chk("R3 per", perClkEn, 0);
    chk("R3 reg", regulatorEn, 1);
    smAlarm = 1; irqPending = 1; cyc(2); smAlarm = 0; irqPending = 0;
    chk("R9 sm/irq ignored", modeStatus, 2);
    wakePin = 16'h0020; cyc(1);
    chk("R9 raw pin wake", modeStatus, 0);
    chk("R9 no reset", resetReq, 0);
    wakePin = '0; wakeEnable = '0; cyc(1);
  endtask

  task automatic t_reject();
    mainClkIsRc = 0;
    request(1'b1, 1'b0, 1'b1);
    cyc(RS + 1);
    chk("R6 stays active", modeStatus, 0);
    chk("R6 core on", coreClkEn, 1);
    chk("R6 flag set", waitRejected, 1);
    request(1'b0, 1'b0, 1'b0);
    chk("R6 flag cleared", waitRejected, 0);
    cyc(RS);
    chk("R6 later sleep", modeStatus, 1);
    irqPending = 1; cyc(1); irqPending = 0;
    mainClkIsRc = 1; cyc(1);
  endtask

  task automatic t_backup();
    request(1'b1, 1'b1, 1'b0);
    cyc(RS);
    chk("R2 status", modeStatus, 3);
    chk("R2 reg", regulatorEn, 0);
    chk("R2 core", coreClkEn, 0);
    chk("R2 per", perClkEn, 0);
    usbWake = 1; irqPending = 1; cyc(2); usbWake = 0; irqPending = 0;
    chk("R7 usb/irq ignored", modeStatus, 3);
    rttAlarm = 1; cyc(1); rttAlarm = 0;
    chk("R7 reset pulse", resetReq, 1);
    chk("R7 reset status", modeStatus, 0);
    chk("R7 reg during reset", regulatorEn, 1);
    cyc(1);
    chk("R7 reset done", resetReq, 0);
    chk("R7 core back", coreClkEn, 1);
  endtask

  task automatic t_debounce();
    // pin 0 active low, pin 1 disabled
    wakeEnable = 16'h0001; wakeActiveHigh = 16'hFFFE; wakePin = 16'h0001;
    debounceLen = 4'd3;
    request(1'b1, 1'b1, 1'b0);
    cyc(RS);
    chk("R8 in backup", modeStatus, 3);
    wakePin = 16'h0002; cyc(3);
    chk("R8 no ticks no wake", modeStatus, 3);
    tickPulse(); tickPulse();
    chk("R8 two ticks", modeStatus, 3);
    slowTick = 1; cyc(1); slowTick = 0; cyc(1);
    chk("R8 third tick wakes", resetReq, 1);
    wakePin = 16'h0001; cyc(2);
    // disabled pin never wakes, then zero-length debounce
    wakeEnable = 16'h0002; debounceLen = 4'd0; wakeActiveHigh = 16'hFFFF; wakePin = 16'h0000;
    request(1'b1, 1'b1, 1'b0);
    cyc(RS);
    wakePin = 16'h0004; cyc(3);
    chk("R8 disabled pin ignored", modeStatus, 3);
    wakePin = 16'h0002; cyc(1);
    chk("R8 zero debounce immediate", resetReq, 1);
    wakePin = '0; wakeEnable = '0; cyc(2);
  endtask

  task automatic t_cancel();
    mainClkIsRc = 1;
    request(1'b1, 1'b0, 1'b1);
    rtcAlarm = 1; cyc(1); rtcAlarm = 0;
    chk("R11 cancelled", modeStatus, 0);
    cyc(RS + 2);
    chk("R11 never entered", modeStatus, 0);
    chk("R11 core on", coreClkEn, 1);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_sleep_wfi();
    t_sleep_wfe();
    t_wait();
    t_reject();
    t_backup();
    t_debounce();
    t_cancel();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule